// File: doc/BRIEF.md
# Calculator Operation and Display Control

This block holds the control state of a small keyed calculator. It remembers whether the next computation adds or subtracts. It also decides whether the display multiplexer shows the digits being keyed in or the computed answer. It accepts single-cycle, already-debounced key pulses for plus, minus, equals, clear and any digit. It drives three outputs: an operation select for the arithmetic datapath, a one-cycle compute strobe, and a select line for the display multiplexer.

A synchronous reset, held for at least one clock, returns the block to its power-on state. In that state the operation is addition and the display shows the keyed entry, so no answer is on show. Every output is registered, and each responds on the clock edge that samples the key pulse. When keys that conflict arrive in the same cycle, a fixed priority settles them. Clear outranks equals, and equals outranks a digit.

Top module: `calc_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `op_sub`=0 (add), `show_answer`=0 (entry shown) and `compute_stb`=0.
- R2: A cycle with `key_add`=1 and `key_sub`=0 sets `op_sub` to 0 (add) from the next edge on.
- R3: A cycle with `key_sub`=1 and `key_add`=0 sets `op_sub` to 1 (subtract) from the next edge on.
- R4: A cycle with both `key_add` and `key_sub` high, or both low, leaves `op_sub` unchanged.
- R5: A cycle with `key_eq`=1 and `key_clr`=0 sets `show_answer` to 1. In the cycle after it, `compute_stb` is 1 for exactly one cycle.
- R6: A cycle with `key_clr`=1 sets `show_answer` to 0 and gives no compute strobe, even if `key_eq` or `key_digit` is also high.
- R7: A cycle with `key_digit`=1 and neither `key_eq` nor `key_clr` sets `show_answer` to 0 (entry shown).
- R8: `compute_stb` is 0 in any cycle that does not follow a cycle with `key_eq`=1 and `key_clr`=0.
- R9: A cycle with none of `key_eq`, `key_clr` or `key_digit` high leaves `show_answer` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| key_add | input | 1 | Plus key pulse |
| key_sub | input | 1 | Minus key pulse |
| key_eq | input | 1 | Equals key pulse |
| key_clr | input | 1 | Clear key pulse |
| key_digit | input | 1 | Any digit key pulse |
| op_sub | output | 1 | Operation select: 0 add, 1 subtract |
| show_answer | output | 1 | Display mux select: 0 entry, 1 answer |
| compute_stb | output | 1 | One-cycle strobe toward the datapath |

## Verification
A wrong stored operation shows on `op_sub` one edge after the key that caused it. It stays wrong until a later plus or minus key, so every cycle in between checks it. A wrong display state shows on `show_answer` one edge after the key. It then persists through idle cycles, which lets the bench catch a lost or spurious update. A fault in the priority or the strobe gating appears in the very next cycle as an extra, missing or wrongly timed `compute_stb` pulse.

// File: rtl/calc_ctrl.sv
module calc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic key_add,
  input  logic key_sub,
  input  logic key_eq,
  input  logic key_clr,
  input  logic key_digit,
  output logic op_sub,
  output logic show_answer,
  output logic compute_stb
);

  logic eq_take;
  logic pick_add;
  logic pick_sub;

  assign eq_take  = key_eq & ~key_clr;
  assign pick_add = key_add & ~key_sub;
  assign pick_sub = key_sub & ~key_add;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_sub      <= 1'b0;
      show_answer <= 1'b0;
      compute_stb <= 1'b0;
    end else begin
      if (pick_sub)      op_sub <= 1'b1;
      else if (pick_add) op_sub <= 1'b0;

      if (key_clr)        show_answer <= 1'b0;
      else if (key_eq)    show_answer <= 1'b1;
      else if (key_digit) show_answer <= 1'b0;

      compute_stb <= eq_take;
    end
  end

endmodule

module calc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic key_add,
  input logic key_sub,
  input logic key_eq,
  input logic key_clr,
  input logic key_digit,
  input logic op_sub,
  input logic show_answer,
  input logic compute_stb
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!op_sub && !show_answer && !compute_stb)); // R1
  AST_ADD_PICK: assert property (@(posedge clk) disable iff (rst)
    (key_add && !key_sub) |=> !op_sub); // R2
  AST_SUB_PICK: assert property (@(posedge clk) disable iff (rst)
    (key_sub && !key_add) |=> op_sub); // R3
  AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (key_add == key_sub) |=> $stable(op_sub)); // R4
  AST_EQ_SHOW: assert property (@(posedge clk) disable iff (rst)
    (key_eq && !key_clr) |=> (show_answer && compute_stb)); // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    key_clr |=> (!show_answer && !compute_stb)); // R6
  AST_DIGIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (key_digit && !key_eq && !key_clr) |=> !show_answer); // R7
  AST_NO_STRAY_STB: assert property (@(posedge clk) disable iff (rst)
    !(key_eq && !key_clr) |=> !compute_stb); // R8
  AST_SHOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!key_eq && !key_clr && !key_digit) |=> $stable(show_answer)); // R9

endmodule

bind calc_ctrl calc_ctrl_chk u_chk (.*);

// File: tb/tb_calc_ctrl.sv
`timescale 1ns/1ps
module tb_calc_ctrl;

  logic clk = 1'b0;
  logic rst, key_add, key_sub, key_eq, key_clr, key_digit;
  logic op_sub, show_answer, compute_stb;

  int n_tests = 0;
  int n_fail  = 0;
  logic exp_op = 1'b0;
  logic exp_show = 1'b0;
  logic exp_stb = 1'b0;
  string tag_op, tag_show, tag_stb;

  always #2.5 clk = ~clk;

  calc_ctrl dut (.*);

  function automatic logic model_op(logic cur, logic r, logic a, logic s);
    if (r) return 1'b0;
    if (s && !a) return 1'b1;
    if (a && !s) return 1'b0;
    return cur;
  endfunction

  function automatic logic model_show(logic cur, logic r, logic e, logic c, logic d);
    if (r || c) return 1'b0;
    if (e) return 1'b1;
    if (d) return 1'b0;
    return cur;
  endfunction

  function automatic logic model_stb(logic r, logic e, logic c);
    return !r && e && !c;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(logic r, logic a, logic s, logic e, logic c, logic d);
    @(negedge clk);
    rst = r; key_add = a; key_sub = s; key_eq = e; key_clr = c; key_digit = d;
    tag_op   = r ? "R1" : (a && !s) ? "R2" : (s && !a) ? "R3" : "R4";
    tag_show = r ? "R1" : c ? "R6" : e ? "R5" : d ? "R7" : "R9";
    tag_stb  = r ? "R1" : c ? "R6" : e ? "R5" : "R8";
    exp_op   = model_op(exp_op, r, a, s);
    exp_show = model_show(exp_show, r, e, c, d);
    exp_stb  = model_stb(r, e, c);
    @(posedge clk);
    #1;
    check(tag_op, "op_sub", op_sub, exp_op);
    check(tag_show, "show_answer", show_answer, exp_show);
    check(tag_stb, "compute_stb", compute_stb, exp_stb);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; key_add = 0; key_sub = 0; key_eq = 0; key_clr = 0; key_digit = 0;
    step(1, 0, 0, 0, 0, 0);           // R1 reset state
    step(1, 0, 1, 1, 0, 0);           // R1 keys ignored under reset
    step(0, 0, 0, 0, 0, 0);           // R4 R9 idle
    step(0, 0, 1, 0, 0, 0);           // R3 subtract
    step(0, 1, 1, 0, 0, 0);           // R4 both held
    step(0, 1, 0, 0, 0, 0);           // R2 add
    step(0, 0, 0, 1, 0, 0);           // R5 equals
    step(0, 0, 0, 0, 0, 0);           // R8 strobe ends, R9 hold
    step(0, 0, 0, 1, 1, 0);           // R6 clear beats equals
    step(0, 0, 0, 1, 0, 1);           // R5 equals beats digit
    step(0, 0, 0, 0, 0, 1);           // R7 digit returns to entry
    step(0, 0, 0, 1, 0, 0);           // R5
    step(0, 0, 0, 0, 1, 1);           // R6 clear with digit
    step(0, 0, 1, 1, 0, 0);           // R3 R5 together
    step(1, 0, 0, 0, 0, 0);           // R1 reset from non-default
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 3000; i++) begin
      logic r, a, s, e, c, d;
      r = ($urandom % 64) == 0;
      a = ($urandom % 4) == 0;
      s = ($urandom % 4) == 0;
      e = ($urandom % 4) == 0;
      c = ($urandom % 6) == 0;
      d = ($urandom % 3) == 0;
      step(r, a, s, e, c, d);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule